// File: doc/BRIEF.md
# Three-Input Boolean Function Class Canonicalizer

The block takes the truth table of a three-input Boolean function, packed into an 8-bit word, and returns the representative of the equivalence class that function belongs to. The representative is the smallest unsigned value reachable from the input word through the transforms allowed by the selected equivalence. Two equivalences are supported. Under permutation equivalence only the order of the inputs may change. Under negation-permutation-negation equivalence the inputs may also be inverted individually and the output may be inverted.

The search is serial. After a start is accepted, the block applies one transform per clock to the captured word and keeps a running minimum. It then raises a one-cycle done pulse, and the representative stays on the output until the next accepted start. Two functions are in the same class exactly when their representatives match, so a cell-matching or classification flow can use the output as a key.

Top module: `fn_class_canon`

## Requirements
- R1: Bit k of `tt_i` (and of `rep_o`) is the function output for the input combination whose binary value is k, with input 0 as the least significant bit. For example, 8'h80 is the three-input AND and 8'h01 is the three-input NOR.
- R2: With `mode_i` = 0 (permutation equivalence), `rep_o` is the minimum unsigned value over the truth tables obtained from the captured word by all 6 input orderings.
- R3: With `mode_i` = 1 (negation-permutation-negation equivalence), `rep_o` is the minimum over all 96 combinations of input ordering, per-input inversion and output inversion.
- R4: Over all 256 input words, mode 0 yields exactly 80 distinct representatives and mode 1 exactly 14.
- R5: `done_o` rises exactly 6 clock edges after the edge that accepts a start in mode 0, and exactly 96 in mode 1. It stays high for one cycle only.
- R6: Once `done_o` has pulsed, `rep_o` keeps its value until the next accepted start, whatever `tt_i` and `mode_i` do in the meantime.
- R7: A start that arrives while a search is running has no effect: neither the result nor the done timing of the running search changes.
- R8: Every representative is a fixed point. Canonicalizing it again in the same mode returns the same value.
- R9: After reset, `done_o` is 0 and `rep_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request a search; accepted only when no search is running |
| tt_i | input | 8 | Truth table to canonicalize, captured on the accepting edge |
| mode_i | input | 1 | 0: permutation equivalence, 1: negation-permutation-negation equivalence |
| done_o | output | 1 | One-cycle pulse when the representative is ready |
| rep_o | output | 8 | Class representative; holds until the next accepted start |

## Verification
The edge on which a start is accepted is taken as reference point zero. The done pulse is due on edge 6 in mode 0 and on edge 96 in mode 1. The bench counts falling edges from that reference, checks that `done_o` first appears at exactly the expected count, reads `rep_o` in that same half cycle, and checks that `done_o` has dropped one cycle later. The hold check and the ignored-start check sample at falling edges several cycles after the pulse, or after the redundant start. This keeps every sample clear of the active edge.

// File: rtl/canon_pkg.sv
package canon_pkg;

  typedef enum logic {
    EQ_PERM = 1'b0,
    EQ_NPN  = 1'b1
  } eq_mode_e;

  function automatic int fact(input int n);
    int r;
    r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

endpackage

// File: rtl/canon_rst_sync.sv
module canon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/canon_xform.sv
module canon_xform
  import canon_pkg::*;
#(
  parameter int N_IN = 3
) (
  input  logic [(1<<N_IN)-1:0]                            tt_i,
  input  logic [$clog2(fact(N_IN))-1:0]                    perm_i,
  input  logic [N_IN-1:0]                                 neg_i,
  input  logic                                            oneg_i,
  output logic [(1<<N_IN)-1:0]                            tt_o
);

  localparam int TT_W   = 1 << N_IN;
  localparam int N_PERM = fact(N_IN);
  localparam int SEL_W  = (N_IN > 1) ? $clog2(N_IN) : 1;

  typedef logic [N_PERM-1:0][N_IN-1:0][SEL_W-1:0] perm_tab_t;

  // Ordering p is decoded from its factorial-base digits at elaboration time.
  function automatic perm_tab_t build_tab();
    perm_tab_t tab;
    tab = '0;
    for (int p = 0; p < N_PERM; p++) begin
      bit used [N_IN];
      int rem;
      for (int j = 0; j < N_IN; j++) used[j] = 1'b0;
      rem = p;
      for (int i = 0; i < N_IN; i++) begin
        int f;
        int d;
        int cnt;
        int pick;
        f    = fact(N_IN - 1 - i);
        d    = rem / f;
        rem  = rem % f;
        cnt  = 0;
        pick = 0;
        for (int j = 0; j < N_IN; j++) begin
          if (!used[j]) begin
            if (cnt == d) pick = j;
            cnt++;
          end
        end
        used[pick] = 1'b1;
        tab[p][i]  = SEL_W'(pick);
      end
    end
    return tab;
  endfunction

  localparam perm_tab_t PERM_TAB = build_tab();

  logic [N_IN-1:0][SEL_W-1:0] sel;

  always_comb begin
    if (int'(perm_i) < N_PERM) sel = PERM_TAB[perm_i];
    else                       sel = PERM_TAB[0];
  end

  // Output row k reads the source row whose input sel[i] carries bit i of k,
  // optionally inverted.
  always_comb begin
    for (int k = 0; k < TT_W; k++) begin
      logic [N_IN-1:0] kb;
      logic [N_IN-1:0] src;
      kb  = N_IN'(k);
      src = '0;
      for (int i = 0; i < N_IN; i++) src[sel[i]] = kb[i] ^ neg_i[i];
      tt_o[k] = tt_i[src] ^ oneg_i;
    end
  end

endmodule

// File: rtl/canon_seq.sv
module canon_seq
  import canon_pkg::*;
#(
  parameter int N_IN = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic                               mode_i,
  output logic                               accept_o,
  output logic                               busy_o,
  output logic                               mode_o,
  output logic [$clog2(fact(N_IN))-1:0]      perm_o,
  output logic [N_IN-1:0]                    neg_o,
  output logic                               oneg_o,
  output logic                               done_o
);

  localparam int N_PERM  = fact(N_IN);
  localparam int PERM_W  = $clog2(N_PERM);
  localparam int STEPS_P = N_PERM;
  localparam int STEPS_N = N_PERM * (1 << N_IN) * 2;
  localparam int CNT_W   = $clog2(STEPS_N + 1);

  logic              busy_q, busy_d;
  logic              mode_q, mode_d;
  logic [PERM_W-1:0] perm_q, perm_d;
  logic [N_IN-1:0]   neg_q,  neg_d;
  logic              oneg_q, oneg_d;
  logic              done_q, done_d;
  logic              accept, perm_last, neg_last, last;

  assign accept    = start_i & ~busy_q;
  assign perm_last = (perm_q == PERM_W'(N_PERM - 1));
  assign neg_last  = &neg_q;
  assign last      = busy_q & perm_last &
                     ((mode_q == EQ_PERM) | (neg_last & oneg_q));

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    perm_d = perm_q;
    neg_d  = neg_q;
    oneg_d = oneg_q;
    done_d = last;
    if (accept) begin
      busy_d = 1'b1;
      mode_d = mode_i;
      perm_d = '0;
      neg_d  = '0;
      oneg_d = 1'b0;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else if (!perm_last) begin
        perm_d = perm_q + PERM_W'(1);
      end else begin
        perm_d = '0;
        if (neg_last) begin
          neg_d  = '0;
          oneg_d = 1'b1;
        end else begin
          neg_d  = neg_q + N_IN'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      perm_q <= '0;
      neg_q  <= '0;
      oneg_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept || busy_q) begin
        mode_q <= mode_d;
        perm_q <= perm_d;
        neg_q  <= neg_d;
        oneg_q <= oneg_d;
      end
    end
  end

  assign accept_o = accept;
  assign busy_o   = busy_q;
  assign mode_o   = mode_q;
  assign perm_o   = perm_q;
  assign neg_o    = neg_q;
  assign oneg_o   = oneg_q;
  assign done_o   = done_q;

  // Checker-side count of the edges spent in a search.
  logic [CNT_W-1:0] chk_steps_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_steps_q <= '0;
    else if (accept)  chk_steps_q <= '0;
    else if (busy_q)  chk_steps_q <= chk_steps_q + CNT_W'(1);
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_step_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (chk_steps_q == ((mode_q == EQ_NPN) ? CNT_W'(STEPS_N) : CNT_W'(STEPS_P))));

  assert_perm_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mode_q == EQ_PERM) |-> (neg_q == '0 && !oneg_q));

  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !last) |=> (busy_q && $stable(mode_q)));

endmodule

// File: rtl/canon_minreg.sv
module canon_minreg #(
  parameter int TT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            upd_i,
  input  logic [TT_W-1:0] cand_i,
  output logic [TT_W-1:0] min_o
);

  logic [TT_W-1:0] min_q, min_d;
  logic            min_en;

  assign min_en = clear_i | (upd_i & (cand_i < min_q));

  always_comb begin
    if (clear_i) min_d = '1;
    else         min_d = cand_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      min_q <= '0;
    else if (min_en) min_q <= min_d;
  end

  assign min_o = min_q;

  assert_min_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clear_i) |=> (min_q <= $past(min_q)));

endmodule

// File: rtl/fn_class_canon.sv
module fn_class_canon
  import canon_pkg::*;
#(
  parameter int N_IN = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [(1<<N_IN)-1:0]  tt_i,
  input  logic                  mode_i,
  output logic                  done_o,
  output logic [(1<<N_IN)-1:0]  rep_o
);

  localparam int TT_W   = 1 << N_IN;
  localparam int PERM_W = $clog2(fact(N_IN));

  logic              rst_sync_n;
  logic              accept, busy, mode_q, oneg, done;
  logic [PERM_W-1:0] perm;
  logic [N_IN-1:0]   neg;
  logic [TT_W-1:0]   tt_q, cand, min_val;

  canon_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  canon_seq #(.N_IN(N_IN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .mode_i   (mode_i),
    .accept_o (accept),
    .busy_o   (busy),
    .mode_o   (mode_q),
    .perm_o   (perm),
    .neg_o    (neg),
    .oneg_o   (oneg),
    .done_o   (done)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  tt_q <= '0;
    else if (accept)  tt_q <= tt_i;
  end

  canon_xform #(.N_IN(N_IN)) u_xform (
    .tt_i   (tt_q),
    .perm_i (perm),
    .neg_i  (neg),
    .oneg_i (oneg),
    .tt_o   (cand)
  );

  canon_minreg #(.TT_W(TT_W)) u_min (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (accept),
    .upd_i   (busy),
    .cand_i  (cand),
    .min_o   (min_val)
  );

  assign done_o = done;
  assign rep_o  = min_val;

  assert_rep_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && !accept) |=> $stable(rep_o));

  assert_rep_not_above_input_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> (rep_o <= tt_q));

  assert_perm_keeps_weight_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && mode_q == EQ_PERM) |-> ($countones(rep_o) == $countones(tt_q)));

  assert_capture_stable_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && !accept) |=> $stable(tt_q));

endmodule

// File: tb/tb_fn_class_canon.sv
module tb_fn_class_canon;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] tt_i;
  logic       mode_i;
  logic       done_o;
  logic [7:0] rep_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fn_class_canon dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tt_i    (tt_i),
    .mode_i  (mode_i),
    .done_o  (done_o),
    .rep_o   (rep_o)
  );

  function automatic logic [7:0] ref_canon(input logic [7:0] tt, input bit npn);
    logic [7:0] best;
    best = 8'hFF;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          if (a != b && b != c && a != c) begin
            for (int m = 0; m < (npn ? 8 : 1); m++)
              for (int o = 0; o < (npn ? 2 : 1); o++) begin
                logic [7:0] t;
                for (int x = 0; x < 8; x++) begin
                  logic [2:0] y;
                  y[a] = x[0] ^ m[0];
                  y[b] = x[1] ^ m[1];
                  y[c] = x[2] ^ m[2];
                  t[x] = tt[y] ^ o[0];
                end
                if (t < best) best = t;
              end
          end
        end
    return best;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Start a search, count falling edges after the accepting edge until done.
  task automatic run_one(input logic [7:0] tt, input bit npn,
                         output logic [7:0] res, output int lat);
    @(negedge clk);
    start_i = 1'b1; tt_i = tt; mode_i = npn;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = rep_o;
  endtask

  initial begin
    logic [7:0] res, res2;
    int lat, exp_lat, uniq;
    bit seen [256];

    rst_n = 1'b0; start_i = 1'b0; tt_i = 8'h00; mode_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: state after reset
    check(done_o == 1'b0, "R9 done after reset", done_o, 0);
    check(rep_o == 8'h00, "R9 rep after reset", rep_o, 0);

    // R1: bit order of the truth table, known class values
    run_one(8'h80, 1'b0, res, lat);
    check(res == 8'h80, "R1 AND3 perm", res, 8'h80);
    run_one(8'h80, 1'b1, res, lat);
    check(res == 8'h01, "R1 AND3 npn", res, 8'h01);
    run_one(8'h02, 1'b0, res, lat);
    check(res == 8'h02, "R1 single minterm perm", res, 8'h02);
    run_one(8'h10, 1'b0, res, lat);
    check(res == 8'h02, "R1 input2 minterm perm", res, 8'h02);

    // R2, R3, R4, R5: full sweeps in both modes
    for (int md = 0; md < 2; md++) begin
      for (int v = 0; v < 256; v++) seen[v] = 1'b0;
      exp_lat = (md == 1) ? 96 : 6;
      for (int v = 0; v < 256; v++) begin
        run_one(8'(v), md[0], res, lat);
        if (md == 0) check(res == ref_canon(8'(v), 1'b0), "R2 perm representative", res, ref_canon(8'(v), 1'b0));
        else         check(res == ref_canon(8'(v), 1'b1), "R3 npn representative", res, ref_canon(8'(v), 1'b1));
        check(lat == exp_lat, "R5 done latency", lat, exp_lat);
        @(negedge clk);
        check(done_o == 1'b0, "R5 done single cycle", done_o, 0);
        seen[res] = 1'b1;
      end
      uniq = 0;
      for (int v = 0; v < 256; v++) if (seen[v]) uniq++;
      check(uniq == ((md == 1) ? 14 : 80), "R4 class count", uniq, (md == 1) ? 14 : 80);
      // R8: each representative maps to itself
      for (int v = 0; v < 256; v++) begin
        if (seen[v]) begin
          run_one(8'(v), md[0], res2, lat);
          check(res2 == 8'(v), "R8 fixed point", res2, v);
        end
      end
    end

    // R6: output holds while inputs change without a start
    run_one(8'h69, 1'b0, res, lat);
    @(negedge clk);
    tt_i = 8'h00; mode_i = 1'b1;
    repeat (5) @(negedge clk);
    check(rep_o == res, "R6 hold after done", rep_o, res);
    check(rep_o == ref_canon(8'h69, 1'b0), "R6 held value", rep_o, ref_canon(8'h69, 1'b0));

    // R7: start while busy is ignored
    @(negedge clk);
    start_i = 1'b1; tt_i = 8'hE8; mode_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; lat = 0;
    @(negedge clk); lat++;
    start_i = 1'b1; tt_i = 8'h01; mode_i = 1'b1;
    @(negedge clk); lat++;
    start_i = 1'b0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 6, "R7 latency unchanged", lat, 6);
    check(rep_o == ref_canon(8'hE8, 1'b0), "R7 result of first start", rep_o, ref_canon(8'hE8, 1'b0));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule